// File: doc/BRIEF.md
# Ones' Complement Adder-Subtractor with End-Around Carry

This block adds or subtracts two signed integers held in ones' complement form. In this form a negative number is the bitwise inverse of the matching positive number, so zero has two encodings: all zeros and all ones. For a subtraction the block inverts the second operand and then adds. In every case a carry out of the top bit is not discarded. It is fed back into bit 0 as an end-around carry. A carry out of the top bit is therefore worth one unit at the bottom.

The datapath is a single combinational path. A ripple-carry first pass produces a raw sum and its carry out. A second stage adds that carry into the raw sum. The final sum and two flags are captured in an output register one clock after a valid input. The overflow flag reports a result that cannot be represented. The negative-zero flag reports an all-ones result.

The operand width is a parameter. The reset input is asynchronous and active low; its release is synchronised inside the block before it reaches the datapath registers.

Top module: `oc_addsub`

## Requirements
- R1: With `op_sub` = 0, a valid input pair gives `sum_out` = `a_in` + `b_in` with end-around carry on the first clock edge after the reset release has been synchronised (for example 1011 + 1100 gives 1000, that is -4 + -3 = -7).
- R2: With `op_sub` = 1, the result is `a_in` plus the bitwise inverse of `b_in`, with end-around carry (for example 0100 - 0011 gives 0001).
- R3: When the first pass produces no carry out of the top bit, the raw sum is the final result (for example 1011 + 0011 gives 1110).
- R4: `ovf_out` is 1 exactly when `a_in` and the effective second operand (`b_in`, or its inverse when subtracting) have the same top bit and the final result has the other top bit.
- R5: `negzero_out` is 1 exactly when the final result is all ones.
- R6: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, `sum_out`, `ovf_out` and `negzero_out` keep their previous values.
- R7: While reset is held, `out_valid`, `sum_out`, `ovf_out` and `negzero_out` are all 0.
- R8: The end-around increment never produces a carry of its own. As a result, whenever the first pass carried, the final result is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operands and `op_sub` |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| a_in | input | DATA_W | First operand, ones' complement |
| b_in | input | DATA_W | Second operand, ones' complement |
| out_valid | output | 1 | Result register holds a new result |
| sum_out | output | DATA_W | Registered final sum |
| ovf_out | output | 1 | Registered overflow flag |
| negzero_out | output | 1 | Registered flag: result is all ones |

## Verification
A broken carry chain or a lost end-around carry makes `sum_out` differ by one unit, one clock after the pair that triggers it. Such a fault shows up only on the pairs whose first pass carries, so the bench runs every operand pair for both operations at 4 bits. A wrong operand inversion or a wrong flag decode is visible on the same cycle as the sum. A stale or wrongly enabled result register shows up as a changed output during idle cycles or as a missing `out_valid`, one cycle after the input.

// File: rtl/oc_pkg.sv
package oc_pkg;

  // operation select encoding on op_sub
  typedef enum logic {
    OC_ADD = 1'b0,
    OC_SUB = 1'b1
  } oc_op_e;

  typedef struct packed {
    logic ovf;
    logic negzero;
  } oc_flags_t;

endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/oc_ripple.sv
module oc_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] s,
  output logic             cout
);

  logic [WIDTH:0] c;

  assign c[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p;
    assign p        = x[i] ^ y[i];
    assign s[i]     = p ^ c[i];
    assign c[i+1]   = (x[i] & y[i]) | (p & c[i]);
  end

  assign cout = c[WIDTH];

endmodule

// File: rtl/oc_incr.sv
module oc_incr #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x,
  input  logic             inc,
  output logic [WIDTH-1:0] s
);

  localparam int PAD_W = WIDTH - 1;

  // half-adder chain; the final carry cannot occur (see R8)
  logic [WIDTH-1:0] c;

  assign c[0] = inc;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign s[i] = x[i] ^ c[i];
    if (i < PAD_W) begin : g_carry
      assign c[i+1] = x[i] & c[i];
    end
  end

endmodule

// File: rtl/oc_flag_gen.sv
module oc_flag_gen
  import oc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             a_msb,
  input  logic             b_msb,
  input  logic [WIDTH-1:0] s,
  output oc_flags_t        flags
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    flags.ovf     = (a_msb == b_msb) && (s[MSB] != a_msb);
    flags.negzero = &s;
  end

endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
  import oc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] sum_out,
  output logic              ovf_out,
  output logic              negzero_out
);

  localparam int MSB = DATA_W - 1;

  logic              rst_q_n;
  oc_op_e            op_sel;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] raw_sum;
  logic              first_carry;
  logic [DATA_W-1:0] final_sum;
  oc_flags_t         flags_d;

  logic              valid_d;
  logic              valid_q;
  logic [DATA_W-1:0] sum_d;
  logic [DATA_W-1:0] sum_q;
  oc_flags_t         flags_nxt;
  oc_flags_t         flags_q;
  logic              load_en;

  oc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // operand conditioning: subtract by inverting the second operand
  always_comb begin
    op_sel = oc_op_e'(op_sub);
    b_eff  = (op_sel == OC_SUB) ? ~b_in : b_in;
  end

  oc_ripple #(
    .WIDTH (DATA_W)
  ) u_pass1 (
    .x    (a_in),
    .y    (b_eff),
    .cin  (1'b0),
    .s    (raw_sum),
    .cout (first_carry)
  );

  oc_incr #(
    .WIDTH (DATA_W)
  ) u_wrap (
    .x   (raw_sum),
    .inc (first_carry),
    .s   (final_sum)
  );

  oc_flag_gen #(
    .WIDTH (DATA_W)
  ) u_flags (
    .a_msb (a_in[MSB]),
    .b_msb (b_eff[MSB]),
    .s     (final_sum),
    .flags (flags_d)
  );

  // next state
  always_comb begin
    load_en   = in_valid;
    valid_d   = in_valid;
    sum_d     = sum_q;
    flags_nxt = flags_q;
    if (load_en) begin
      sum_d     = final_sum;
      flags_nxt = flags_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
      sum_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= valid_d;
      sum_q   <= sum_d;
      flags_q <= flags_nxt;
    end
  end

  assign out_valid   = valid_q;
  assign sum_out     = sum_q;
  assign ovf_out     = flags_q.ovf;
  assign negzero_out = flags_q.negzero;

endmodule

// File: rtl/oc_addsub_chk.sv
module oc_addsub_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              in_valid,
  input logic              op_sub,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic              first_carry,
  input logic [DATA_W-1:0] final_sum,
  input logic              out_valid,
  input logic [DATA_W-1:0] sum_out,
  input logic              ovf_out,
  input logic              negzero_out
);

  localparam int MSB = DATA_W - 1;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R6

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(sum_out) && $stable(ovf_out) && $stable(negzero_out))); // R6

  AST_ADD_ZERO_IDENTITY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !op_sub && (b_in == '0)) |=> (sum_out == $past(a_in))); // R1

  AST_SELF_SUB_NEGZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && op_sub && (a_in == b_in)) |=> negzero_out); // R5

  AST_MIXED_SIGN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !op_sub && (a_in[MSB] != b_in[MSB])) |=> !ovf_out); // R4

  AST_NO_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_q_n)
    first_carry |-> (final_sum != '0)); // R8

endmodule

bind oc_addsub oc_addsub_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .in_valid    (in_valid),
  .op_sub      (op_sub),
  .a_in        (a_in),
  .b_in        (b_in),
  .first_carry (first_carry),
  .final_sum   (final_sum),
  .out_valid   (out_valid),
  .sum_out     (sum_out),
  .ovf_out     (ovf_out),
  .negzero_out (negzero_out)
);

// File: tb/oc_addsub_bench.sv
module oc_addsub_bench;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         op_sub;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic         out_valid;
  logic [W-1:0] sum_out;
  logic         ovf_out;
  logic         negzero_out;

  int total = 0;
  int bad   = 0;
  logic chk_en = 1'b0;
  logic done   = 1'b0;

  // reference state
  logic         exp_v;
  logic [W-1:0] exp_s;
  logic         exp_ov;
  logic         exp_nz;
  logic         exp_cy;
  logic         exp_sub;

  oc_addsub #(
    .DATA_W (W)
  ) u_oc_addsub (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_sub      (op_sub),
    .a_in        (a_in),
    .b_in        (b_in),
    .out_valid   (out_valid),
    .sum_out     (sum_out),
    .ovf_out     (ovf_out),
    .negzero_out (negzero_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic void ref_calc(input int a, input int b, input bit sub,
                                   output int s, output bit ov, output bit nz,
                                   output bit cy);
    int be;
    int t;
    be = sub ? ((~b) & 15) : b;
    t  = a + be;
    cy = (t > 15);
    if (cy) t = t - 16 + 1;
    s  = t;
    ov = (((a >> 3) & 1) == ((be >> 3) & 1)) && (((s >> 3) & 1) != ((a >> 3) & 1));
    nz = (s == 15);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_s <= '0; exp_ov <= 1'b0; exp_nz <= 1'b0;
      exp_cy <= 1'b0; exp_sub <= 1'b0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        int s; bit ov; bit nz; bit cy;
        ref_calc(int'(a_in), int'(b_in), op_sub, s, ov, nz, cy);
        exp_s   <= s[W-1:0];
        exp_ov  <= ov;
        exp_nz  <= nz;
        exp_cy  <= cy;
        exp_sub <= op_sub;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the reference model on every clock
  always @(negedge clk) begin
    if (chk_en) begin
      check("R6 valid", int'(out_valid), int'(exp_v));
      if (exp_v) begin
        check(exp_sub ? "R2 sum" : "R1 sum", int'(sum_out), int'(exp_s));
        check(exp_cy ? "R8 wrapped sum" : "R3 raw sum", int'(sum_out), int'(exp_s));
        check("R4 ovf", int'(ovf_out), int'(exp_ov));
        check("R5 negzero", int'(negzero_out), int'(exp_nz));
      end else begin
        check("R6 hold sum", int'(sum_out), int'(exp_s));
        check("R6 hold flags", int'({ovf_out, negzero_out}), int'({exp_ov, exp_nz}));
      end
    end
  end

  task automatic drive(input int a, input int b, input bit sub, input bit v);
    @(negedge clk);
    a_in     = a[W-1:0];
    b_in     = b[W-1:0];
    op_sub   = sub;
    in_valid = v;
  endtask

  task automatic directed(input int a, input int b, input bit sub,
                          input int exp, input string tag);
    drive(a, b, sub, 1'b1);
    drive(0, 0, 1'b0, 1'b0);
    check(tag, int'(sum_out), exp);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    check("R7 reset valid", int'(out_valid), 0);
    check("R7 reset sum", int'(sum_out), 0);
    check("R7 reset flags", int'({ovf_out, negzero_out}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;

    directed(4'b1011, 4'b1100, 1'b0, 4'b1000, "R1 example -4+-3");
    directed(4'b0100, 4'b0011, 1'b1, 4'b0001, "R2 example 4-3");
    directed(4'b1011, 4'b0011, 1'b0, 4'b1110, "R3 example -4+3");
    directed(4'b0111, 4'b1000, 1'b0, 4'b1111, "R5 example 7+-7");
    repeat (3) drive(5, 9, 1'b1, 1'b0);

    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          drive(a, b, op[0], 1'b1);
          if (((a * 16 + b) % 7) == 3) drive(b, a, ~op[0], 1'b0);
        end
      end
    end
    drive(0, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule